// File: doc/BRIEF.md
# GPIO Signal Crossbar

This block sits between a chip's internal peripherals and its general-purpose pads. It holds three tables of per-lane select codes, written over a plain 32-bit register bus. One table chooses, for every pad, which internal signal drives its output level. Another chooses, for every pad, which internal enable signal turns its driver on. The third chooses, for every peripheral input, which pad feeds it. Each table lane is one byte of a 32-bit word, and each word holds four lanes. A read-only bank reports the synchronised level of every pad, packed one bit per pad.

All three tables use the same code scheme. Codes 0 and 1 are constant low and constant high. A code of 2 or more picks entry `code - 2` of the table's source list. For the output tables, that list is the peripherals' data or enable signals. For the input table, it is the synchronised pads. A code past the end of the list gives constant low. Pad inputs pass through two flops before they are used anywhere, so peripheral inputs and the level bank both lag the pads by two clocks. Writes land on the clock edge. Reads are combinational from the address.

Top module: `gpxb_top`

## Requirements
- R1: After reset, every table lane holds code 0. Therefore every pad driver is off (`pad_oe` all 0), every pad output is 0, every peripheral input is 0, and every table word reads 0.
- R2: The output-enable table starts at byte address 0x00. Pad n sits in word n/4 at bits [8*(n%4)+5 : 8*(n%4)], a 6-bit field, and the two bits above it read 0.
- R3: The output-data table starts at byte address 0x40 with the same lane placement and a 7-bit field per lane. The top bit of each byte reads 0.
- R4: The input table starts at byte address 0x80. Peripheral input j sits in word j/4 at bits [8*(j%4)+6 : 8*(j%4)], a 7-bit field, and the top bit of each byte reads 0.
- R5: An output-data code gives the following pad output. Code 0 gives 0. Code 1 gives 1. A code c from 2 to 65 gives `periph_do[c-2]`. Any code of 66 or more gives 0.
- R6: An output-enable code gives the following driver enable. Code 0 turns the driver off. Code 1 turns it on. A code c from 2 to 33 follows `periph_oe[c-2]`. Any code of 34 or more turns the driver off.
- R7: An input code gives the following peripheral input. Code 0 gives 0. Code 1 gives 1. A code c from 2 to 65 gives synchronised pad c-2. Any code of 66 or more gives 0.
- R8: The level bank starts at byte address 0x118. Pad n reads as bit n%32 of word n/32. A pad change appears in the bank, and on routed peripheral inputs, after exactly two rising clock edges.
- R9: Writes to the level bank, or to an address outside all tables and the bank, change no table lane. A read from an unmapped address returns 0.
- R10: A write changes the table, and any routed output, at the clock edge that samples it and not before. A read returns the addressed word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_wen | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| periph_do | input | 64 | Internal output-data sources |
| periph_oe | input | 32 | Internal output-enable sources |
| pad_in | input | 64 | Pad input levels, asynchronous |
| pad_out | output | 64 | Level driven toward each pad |
| pad_oe | output | 64 | Driver enable for each pad, 1 = driving |
| periph_di | output | 32 | Routed inputs to peripherals |

## Verification
The assertions assume that `rst_n` is held low across at least one rising edge before the first bus access. They also assume that bus signals are stable around each rising edge. The pad-sync check further assumes that `pad_in` is sampled by the same clock, so a change is seen at one specific edge. The bench meets these assumptions in three ways:
- It drives every input on the falling edge.
- It releases reset only after several edges.
- It makes pad changes only at falling edges, and it allows three edges before it reads any routed input.

// File: rtl/gpxb_pkg.sv
// Package: shared lane geometry and code constants for the GPIO crossbar.
// Assumes byte-wide lanes, four lanes per 32-bit word, 32 pads per level word.
package gpxb_pkg;
    localparam int LANE_W         = 8;
    localparam int LANES_PER_WORD = 4;
    localparam int DATA_W         = 32;
    localparam int PADS_PER_LVL   = 32;
    localparam int CODE_LOW       = 0;
    localparam int CODE_HIGH      = 1;
    localparam int CODE_FIRST_SRC = 2;

    // Number of 32-bit words needed to hold a count of byte lanes.
    function automatic int words_for_lanes(input int lanes);
        return (lanes + LANES_PER_WORD - 1) / LANES_PER_WORD;
    endfunction
endpackage

// File: rtl/gpxb_sel_table.sv
// Module: one bank of byte-lane select registers on the register bus.
// Holds NUM_LANES codes of FIELD_W bits, four per word starting at BASE.
// Assumes word-aligned byte addresses. Bits above FIELD_W in a lane are not
// stored and read as 0. Reads are combinational; writes land on the clock edge.
module gpxb_sel_table
    import gpxb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LANES = 64,
    parameter int FIELD_W   = 7,
    parameter int BASE      = 0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              wen,
    output logic [NUM_LANES-1:0][FIELD_W-1:0] codes,
    output logic [DATA_W-1:0]                 rd_data
);
    localparam int NUM_WORDS = words_for_lanes(NUM_LANES);
    localparam int LIMIT     = BASE + LANES_PER_WORD * NUM_WORDS;

    logic [31:0] addr32;
    logic [31:0] widx32;
    logic        hit;

    // Decode whether the address falls in this table, and which word it selects.
    always_comb begin
        addr32 = 32'(addr);
        hit    = (addr32 >= 32'(BASE)) && (addr32 < 32'(LIMIT));
        widx32 = (addr32 - 32'(BASE)) >> 2;
    end

    // Store the written field of every lane in the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            codes <= '0;
        end else if (wen && hit) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                if (widx32 == 32'(l / LANES_PER_WORD))
                    codes[l] <= wdata[LANE_W*(l%LANES_PER_WORD) +: FIELD_W];
            end
        end
    end

    // Assemble the addressed word for readback, with unused bits at 0.
    always_comb begin
        rd_data = '0;
        if (hit) begin
            for (int l = 0; l < NUM_LANES; l++) begin
                if (widx32 == 32'(l / LANES_PER_WORD))
                    rd_data[LANE_W*(l%LANES_PER_WORD) +: FIELD_W] = codes[l];
            end
        end
    end
endmodule

// File: rtl/gpxb_route_mux.sv
// Module: maps each destination's select code to a source bit or a constant.
// Code 0 gives low and code 1 gives high. Code c >= 2 gives src[c-2] if that
// source exists, and low otherwise. Purely combinational.
module gpxb_route_mux
    import gpxb_pkg::*;
#(
    parameter int NUM_DST = 64,
    parameter int NUM_SRC = 64,
    parameter int CODE_W  = 7
) (
    input  logic [NUM_DST-1:0][CODE_W-1:0] sel,
    input  logic [NUM_SRC-1:0]             src,
    output logic [NUM_DST-1:0]             dst
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int LAST  = CODE_FIRST_SRC + NUM_SRC;

    logic [31:0] code32;

    // Resolve every destination from its code.
    always_comb begin
        code32 = '0;
        for (int d = 0; d < NUM_DST; d++) begin
            code32 = 32'(sel[d]);
            dst[d] = 1'b0;
            if (code32 == 32'(CODE_HIGH))
                dst[d] = 1'b1;
            else if (code32 >= 32'(CODE_FIRST_SRC) && code32 < 32'(LAST))
                dst[d] = src[IDX_W'(code32 - 32'(CODE_FIRST_SRC))];
        end
    end
endmodule

// File: rtl/gpxb_sync2.sv
// Module: two-flop synchroniser for a vector of asynchronous pad levels.
// Assumes each bit is independent; no multi-bit coherence is given.
module gpxb_sync2 #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Shift pad levels through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpxb_top.sv
// Module: GPIO signal crossbar top.
// Three select tables steer the following:
//   - peripheral output data onto pads;
//   - peripheral enables onto pad drivers;
//   - synchronised pads onto peripheral inputs.
// A read-only bank reports the synchronised pad levels.
// Assumes a single clock domain for the bus and peripherals. Pads are asynchronous.
module gpxb_top
    import gpxb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_PADS   = 64,
    parameter int NUM_DI     = 32,
    parameter int NUM_DO_SRC = 64,
    parameter int NUM_OE_SRC = 32,
    parameter int OE_W       = 6,
    parameter int DO_W       = 7,
    parameter int DI_W       = 7,
    parameter int OE_BASE    = 'h000,
    parameter int DO_BASE    = 'h040,
    parameter int DI_BASE    = 'h080,
    parameter int LVL_BASE   = 'h118
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_wen,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_DO_SRC-1:0] periph_do,
    input  logic [NUM_OE_SRC-1:0] periph_oe,
    input  logic [NUM_PADS-1:0]   pad_in,
    output logic [NUM_PADS-1:0]   pad_out,
    output logic [NUM_PADS-1:0]   pad_oe,
    output logic [NUM_DI-1:0]     periph_di
);
    localparam int LVL_WORDS = (NUM_PADS + PADS_PER_LVL - 1) / PADS_PER_LVL;
    localparam int LVL_LIMIT = LVL_BASE + 4 * LVL_WORDS;

    logic [NUM_PADS-1:0][OE_W-1:0] oe_codes;
    logic [NUM_PADS-1:0][DO_W-1:0] do_codes;
    logic [NUM_DI-1:0][DI_W-1:0]   di_codes;
    logic [NUM_PADS-1:0]           pad_sync;
    logic [DATA_W-1:0]             oe_rd, do_rd, di_rd, lvl_rd;
    logic [31:0]                   addr32;
    logic [31:0]                   lvl_widx;
    logic                          lvl_hit;

    gpxb_sel_table #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_PADS), .FIELD_W(OE_W), .BASE(OE_BASE))
    u_oe_table (.clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
                .wen(bus_wen), .codes(oe_codes), .rd_data(oe_rd));

    gpxb_sel_table #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_PADS), .FIELD_W(DO_W), .BASE(DO_BASE))
    u_do_table (.clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
                .wen(bus_wen), .codes(do_codes), .rd_data(do_rd));

    gpxb_sel_table #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_DI), .FIELD_W(DI_W), .BASE(DI_BASE))
    u_di_table (.clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
                .wen(bus_wen), .codes(di_codes), .rd_data(di_rd));

    gpxb_sync2 #(.WIDTH(NUM_PADS))
    u_pad_sync (.clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pad_sync));

    gpxb_route_mux #(.NUM_DST(NUM_PADS), .NUM_SRC(NUM_DO_SRC), .CODE_W(DO_W))
    u_do_mux (.sel(do_codes), .src(periph_do), .dst(pad_out));

    gpxb_route_mux #(.NUM_DST(NUM_PADS), .NUM_SRC(NUM_OE_SRC), .CODE_W(OE_W))
    u_oe_mux (.sel(oe_codes), .src(periph_oe), .dst(pad_oe));

    gpxb_route_mux #(.NUM_DST(NUM_DI), .NUM_SRC(NUM_PADS), .CODE_W(DI_W))
    u_di_mux (.sel(di_codes), .src(pad_sync), .dst(periph_di));

    // Decode the level-bank window and its word index.
    always_comb begin
        addr32   = 32'(bus_addr);
        lvl_hit  = (addr32 >= 32'(LVL_BASE)) && (addr32 < 32'(LVL_LIMIT));
        lvl_widx = (addr32 - 32'(LVL_BASE)) >> 2;
    end

    // Pack synchronised pad levels, 32 per word, for readback.
    always_comb begin
        lvl_rd = '0;
        if (lvl_hit) begin
            for (int b = 0; b < NUM_PADS; b++) begin
                if (lvl_widx == 32'(b / PADS_PER_LVL))
                    lvl_rd[b % PADS_PER_LVL] = pad_sync[b];
            end
        end
    end

    // Merge read sources; windows do not overlap, so at most one is non-zero.
    always_comb begin
        bus_rdata = oe_rd | do_rd | di_rd | lvl_rd;
    end
endmodule

// File: rtl/gpxb_checker.sv
// Module: assertion checker for gpxb_top, attached by bind.
// Observes the top's ports, its select tables and its synchronised pad vector.
module gpxb_checker #(
    parameter int ADDR_W     = 12,
    parameter int NUM_PADS   = 64,
    parameter int NUM_DI     = 32,
    parameter int OE_W       = 6,
    parameter int DO_W       = 7,
    parameter int DI_W       = 7,
    parameter int DO_BASE    = 'h040,
    parameter int LVL_BASE   = 'h118
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [31:0]                   bus_wdata,
    input logic                          bus_wen,
    input logic [NUM_PADS-1:0]           pad_in,
    input logic [NUM_PADS-1:0]           pad_out,
    input logic [NUM_PADS-1:0]           pad_oe,
    input logic [NUM_DI-1:0]             periph_di,
    input logic [NUM_PADS-1:0][OE_W-1:0] oe_codes,
    input logic [NUM_PADS-1:0][DO_W-1:0] do_codes,
    input logic [NUM_DI-1:0][DI_W-1:0]   di_codes,
    input logic [NUM_PADS-1:0]           pad_sync
);
    localparam int LVL_LIMIT = LVL_BASE + 4 * ((NUM_PADS + 31) / 32);

    logic lvl_write;
    // Flag a write that lands in the read-only level bank.
    always_comb begin
        lvl_write = bus_wen && (32'(bus_addr) >= 32'(LVL_BASE))
                            && (32'(bus_addr) < 32'(LVL_LIMIT));
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && periph_di == '0));

    assert_sync_two_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (pad_sync == $past(pad_in, 2)));

    assert_level_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_write |=> ($stable(oe_codes) && $stable(do_codes) && $stable(di_codes)));

    assert_write_next_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(DO_BASE)) |=> (do_codes[0] == $past(bus_wdata[DO_W-1:0])));

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
        assert_oe_code0_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (oe_codes[g] == '0) |-> !pad_oe[g]);
        assert_do_code1_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (do_codes[g] == DO_W'(1)) |-> pad_out[g]);
    end

    for (genvar g = 0; g < NUM_DI; g++) begin : g_di
        assert_di_code1_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (di_codes[g] == DI_W'(1)) |-> periph_di[g]);
    end
endmodule

bind gpxb_top gpxb_checker #(
    .ADDR_W(ADDR_W), .NUM_PADS(NUM_PADS), .NUM_DI(NUM_DI), .OE_W(OE_W),
    .DO_W(DO_W), .DI_W(DI_W), .DO_BASE(DO_BASE), .LVL_BASE(LVL_BASE)
) u_gpxb_checker (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wen(bus_wen), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .periph_di(periph_di), .oe_codes(oe_codes), .do_codes(do_codes),
    .di_codes(di_codes), .pad_sync(pad_sync)
);

// File: tb/tb_gpxb_top.sv
// Directed bench for gpxb_top: one task per scenario, each checking its results.
module tb_gpxb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] periph_do = '0;
    logic [31:0] periph_oe = '0;
    logic [63:0] pad_in = '0;
    logic [63:0] pad_out;
    logic [63:0] pad_oe;
    logic [31:0] periph_di;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gpxb_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wen(bus_wen), .bus_rdata(bus_rdata), .periph_do(periph_do),
        .periph_oe(periph_oe), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .periph_di(periph_di)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle_pads(input logic [63:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_tables();
        for (int w = 0; w < 16; w++) begin
            bus_write(12'(w * 4), 32'h0);
            bus_write(12'('h40 + w * 4), 32'h0);
        end
        for (int w = 0; w < 8; w++) bus_write(12'('h80 + w * 4), 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pad_oe", pad_oe, 64'h0);
        check("R1 pad_out", pad_out, 64'h0);
        check("R1 periph_di", {32'h0, periph_di}, 64'h0);
        bus_read(12'h000, d); check("R1 oe word", {32'h0, d}, 64'h0);
        bus_read(12'h07C, d); check("R1 do word", {32'h0, d}, 64'h0);
        bus_read(12'h09C, d); check("R1 di word", {32'h0, d}, 64'h0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        periph_do = '1; periph_oe = '1;
        settle_pads('1);
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_read(12'h004, d); check("R2 oe field width", {32'h0, d}, 64'h3F3F_3F3F);
        check("R6 oe code 63 off", {60'h0, pad_oe[7:4]}, 64'h0);
        bus_write(12'h07C, 32'hFFFF_FFFF);
        bus_read(12'h07C, d); check("R3 do field width", {32'h0, d}, 64'h7F7F_7F7F);
        check("R5 do code 127 low", {60'h0, pad_out[63:60]}, 64'h0);
        bus_write(12'h09C, 32'hFFFF_FFFF);
        bus_read(12'h09C, d); check("R4 di field width", {32'h0, d}, 64'h7F7F_7F7F);
        check("R7 di code 127 zero", {60'h0, periph_di[31:28]}, 64'h0);
        bus_write(12'h044, 32'h0000_0100);
        check("R3 lane placement pad5", {60'h0, pad_out[7:4]}, 64'h2);
        clear_tables();
    endtask

    task automatic t_do_route();
        logic [63:0] v;
        bus_write(12'h040, {8'd65, 8'd2, 8'd0, 8'd1});
        v = 64'hA5A5_0F0F_3C3C_9669;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); periph_do = v; #1;
            check("R5 do codes 1/0/2/65", {60'h0, pad_out[3:0]},
                  {60'h0, v[63], v[0], 1'b0, 1'b1});
            v = ~v;
        end
        periph_do = '1;
        bus_write(12'h044, 32'd66);
        check("R5 do code 66 low", {63'h0, pad_out[4]}, 64'h0);
        clear_tables();
    endtask

    task automatic t_oe_route();
        logic [31:0] v;
        bus_write(12'h000, {8'd33, 8'd2, 8'd0, 8'd1});
        v = 32'h8000_0001;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); periph_oe = v; #1;
            check("R6 oe codes 1/0/2/33", {60'h0, pad_oe[3:0]},
                  {60'h0, v[31], v[0], 1'b0, 1'b1});
            v = ~v;
        end
        periph_oe = '1;
        bus_write(12'h004, 32'd34);
        check("R6 oe code 34 off", {63'h0, pad_oe[4]}, 64'h0);
        clear_tables();
    endtask

    task automatic t_di_route();
        logic [63:0] v;
        bus_write(12'h080, {8'd65, 8'd2, 8'd1, 8'd0});
        bus_write(12'h084, {16'h0, 8'd42, 8'd66});
        v = 64'h8000_0100_0000_0001;
        for (int k = 0; k < 2; k++) begin
            settle_pads(v);
            check("R7 di codes 0/1/2/65", {60'h0, periph_di[3:0]},
                  {60'h0, v[63], v[0], 1'b1, 1'b0});
            check("R7 di pad40", {63'h0, periph_di[5]}, {63'h0, v[40]});
            v = ~v;
        end
        settle_pads('1);
        check("R7 di code 66 zero", {63'h0, periph_di[4]}, 64'h0);
        clear_tables();
    endtask

    task automatic t_sync();
        logic [31:0] d;
        settle_pads('0);
        pad_in[5] = 1'b1; pad_in[40] = 1'b1;
        @(negedge clk);
        bus_read(12'h118, d); check("R8 one edge word0", {32'h0, d}, 64'h0);
        bus_read(12'h11C, d); check("R8 one edge word1", {32'h0, d}, 64'h0);
        @(negedge clk);
        bus_read(12'h118, d); check("R8 two edges word0", {32'h0, d}, 64'h20);
        bus_read(12'h11C, d); check("R8 two edges word1", {32'h0, d}, 64'h100);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        settle_pads(64'h1234_5678_9ABC_DEF0);
        bus_write(12'h000, 32'h0101_0101);
        bus_write(12'h118, 32'h0);
        bus_write(12'h11C, 32'h0);
        bus_read(12'h118, d); check("R9 level word0 intact", {32'h0, d}, 64'h9ABC_DEF0);
        bus_read(12'h11C, d); check("R9 level word1 intact", {32'h0, d}, 64'h1234_5678);
        bus_write(12'h100, 32'hFFFF_FFFF);
        bus_read(12'h000, d); check("R9 oe word intact", {32'h0, d}, 64'h0101_0101);
        bus_read(12'h100, d); check("R9 unmapped read", {32'h0, d}, 64'h0);
        check("R9 pad_oe intact", {60'h0, pad_oe[3:0]}, 64'hF);
        check("R9 pad_oe others", {4'h0, pad_oe[63:4]}, 64'h0);
        clear_tables();
    endtask

    task automatic t_timing();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = 12'h040; bus_wdata = 32'h1; bus_wen = 1'b1;
        #1;
        check("R10 before edge", {63'h0, pad_out[0]}, 64'h0);
        @(posedge clk); #1;
        check("R10 after edge", {63'h0, pad_out[0]}, 64'h1);
        @(negedge clk); bus_wen = 1'b0;
        bus_read(12'h040, d); check("R10 same-cycle read", {32'h0, d}, 64'h1);
        clear_tables();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_do_route();
        t_oe_route();
        t_di_route();
        t_sync();
        t_ignored();
        t_timing();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule